// File: doc/BRIEF.md
# Presettable Synchronous Binary Counter

This block is a four-bit binary counter in which every bit changes on the rising edge of one clock. It steps through the natural binary sequence and returns to zero after fifteen. A parallel data word can be written into it, and it can be cleared. Both operations are synchronous, active low, and take effect whatever the enables are doing.

Counting needs two enables at once. One is a parallel enable that only gates the count. The other is a trickle enable that gates the count and also qualifies the carry output. The carry output is high while the count sits at fifteen and the trickle enable is high. Several copies can therefore be chained into a wider counter: each stage's carry drives the trickle enable of the next stage, and a shared parallel enable starts or stops the whole chain.

Top module: `preset_counter`

## Requirements
- R1: When `clr_n` is low at a rising edge, `q` becomes 0 after that edge, whatever `load_n`, `en_par`, `en_trk` and `din` are.
- R2: When `clr_n`, `load_n`, `en_par` and `en_trk` are all high at a rising edge, `q` becomes (`q` + 1) modulo 16, so 15 is followed by 0.
- R3: When `clr_n` is high and `load_n` is low at a rising edge, `q` takes the value of `din`, even if one or both enables are low.
- R4: Clear has priority over load: with both `clr_n` and `load_n` low at an edge, `q` becomes 0 and not `din`.
- R5: When `clr_n` and `load_n` are high and either `en_par` or `en_trk` is low at an edge, `q` keeps its value.
- R6: `carry` is combinational and equals 1 exactly when `q` is 15 and `en_trk` is 1. Otherwise it is 0.
- R7: `carry` does not depend on `en_par`. With `q` at 15 and `en_trk` high, `carry` stays 1 while `en_par` is low.
- R8: Loading 12 and then counting with both enables high produces the sequence 12, 13, 14, 15, 0, 1, 2 on successive edges. `carry` is high only in the cycle where `q` is 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all state |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| en_par | input | 1 | Parallel count enable, gates counting only |
| en_trk | input | 1 | Trickle count enable, gates counting and the carry |
| din | input | 4 | Parallel load data |
| q | output | 4 | Current count |
| carry | output | 1 | Terminal count (15) qualified by `en_trk` |

## Verification
The hardest case to reach is the terminal count held steady with the two enables split. Only in that state can the bench show that the parallel enable leaves the carry alone while still stopping the count. The bench reaches it by loading 15 directly, then toggling `en_par` and `en_trk` one at a time while the count cannot move. A long run of random control values then combines clear, load and both enables in every way. Loads are drawn often enough that the count keeps coming back near the wrap point.

// File: rtl/preset_counter_pkg.sv
package preset_counter_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
  import preset_counter_pkg::*;
(
  input  logic    clr_n,
  input  logic    load_n,
  input  logic    en_par,
  input  logic    en_trk,
  output cnt_op_e op
);
  // Fixed priority: clear, then load, then count, else hold.
  function automatic cnt_op_e pick_op(input logic c_n, input logic l_n,
                                      input logic ep, input logic et);
    if (!c_n)          return OP_CLEAR;
    else if (!l_n)     return OP_LOAD;
    else if (ep && et) return OP_COUNT;
    else               return OP_HOLD;
  endfunction

  always_comb op = pick_op(clr_n, load_n, en_par, en_trk);
endmodule

// File: rtl/cnt_toggle_reg.sv
module cnt_toggle_reg
  import preset_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  cnt_op_e          op,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q
);
  localparam int CHAIN = WIDTH + 1;

  logic [CHAIN-1:0] tog_chain;
  logic [WIDTH-1:0] q_inc;
  logic [WIDTH-1:0] q_next;

  assign tog_chain[0] = 1'b1;

  // Each bit toggles when every lower bit is one.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign tog_chain[i+1] = tog_chain[i] & q[i];
    assign q_inc[i]       = q[i] ^ tog_chain[i];
  end

  always_comb begin
    unique case (op)
      OP_CLEAR: q_next = '0;
      OP_LOAD:  q_next = din;
      OP_COUNT: q_next = q_inc;
      default:  q_next = q;
    endcase
  end

  always_ff @(posedge clk) q <= q_next;

  logic unused_top;
  assign unused_top = tog_chain[CHAIN-1];
endmodule

// File: rtl/tc_decode.sv
module tc_decode #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic             en_trk,
  output logic             terminal,
  output logic             carry
);
  localparam logic [WIDTH-1:0] TC_VAL = {WIDTH{1'b1}};

  function automatic logic at_terminal(input logic [WIDTH-1:0] v);
    return v == TC_VAL;
  endfunction

  assign terminal = at_terminal(q);
  assign carry    = terminal & en_trk;
endmodule

// File: rtl/preset_counter.sv
module preset_counter
  import preset_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             en_par,
  input  logic             en_trk,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             carry
);
  cnt_op_e op_w;
  logic    terminal_w;

  cnt_ctrl u_ctrl (
    .clr_n (clr_n),
    .load_n(load_n),
    .en_par(en_par),
    .en_trk(en_trk),
    .op    (op_w)
  );

  cnt_toggle_reg #(.WIDTH(WIDTH)) u_reg (
    .clk(clk),
    .op (op_w),
    .din(din),
    .q  (q)
  );

  tc_decode #(.WIDTH(WIDTH)) u_tc (
    .q       (q),
    .en_trk  (en_trk),
    .terminal(terminal_w),
    .carry   (carry)
  );
endmodule

// File: rtl/preset_counter_chk.sv
module preset_counter_chk
  import preset_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             clr_n,
  input logic             load_n,
  input logic             en_par,
  input logic             en_trk,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] q,
  input logic             carry,
  input cnt_op_e          op_w,
  input logic             terminal_w
);
  // State is known only after a first clear.
  logic primed = 1'b0;
  always_ff @(posedge clk) if (!clr_n) primed <= 1'b1;

  p_clear_r1: assert property (@(posedge clk) disable iff (!primed)
    !clr_n |=> (q == '0));

  p_count_r2: assert property (@(posedge clk) disable iff (!primed)
    (clr_n && load_n && en_par && en_trk) |=> (q == WIDTH'($past(q) + 1'b1)));

  p_load_r3: assert property (@(posedge clk) disable iff (!primed)
    (clr_n && !load_n) |=> (q == $past(din)));

  p_clear_wins_r4: assert property (@(posedge clk) disable iff (!primed)
    (!clr_n && !load_n) |-> (op_w == OP_CLEAR));

  p_hold_r5: assert property (@(posedge clk) disable iff (!primed)
    (clr_n && load_n && !(en_par && en_trk)) |=> $stable(q));

  p_carry_r6: assert property (@(posedge clk) disable iff (!primed)
    carry |-> (q == {WIDTH{1'b1}}) && en_trk);

  p_carry_par_r7: assert property (@(posedge clk) disable iff (!primed)
    (terminal_w && en_trk && !en_par) |-> carry);
endmodule

bind preset_counter preset_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .clr_n     (clr_n),
  .load_n    (load_n),
  .en_par    (en_par),
  .en_trk    (en_trk),
  .din       (din),
  .q         (q),
  .carry     (carry),
  .op_w      (op_w),
  .terminal_w(terminal_w)
);

// File: tb/preset_counter_tb_top.sv
module preset_counter_tb_top;
  logic       clk = 1'b0;
  logic       clr_n = 1'b1, load_n = 1'b1, en_par = 1'b0, en_trk = 1'b0;
  logic [3:0] din = 4'd0;
  logic [3:0] q;
  logic       carry;

  int n_checks = 0;
  int n_errors = 0;
  int model = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  preset_counter dut_i (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_par(en_par),
    .en_trk(en_trk), .din(din), .q(q), .carry(carry)
  );

  task automatic check(input string tag, input int actual, input int expected);
    n_checks++;
    if (actual != expected) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, actual, expected, $time);
    end
  endtask

  // Apply controls, check carry, clock once, update model, check count.
  task automatic step(input string tag, input bit c, input bit l,
                      input bit ep, input bit et, input int d);
    clr_n = c; load_n = l; en_par = ep; en_trk = et; din = 4'(d);
    #1;
    check({tag, " carry R6"}, int'(carry), (model == 15 && et) ? 1 : 0);
    @(posedge clk);
    if (c == 0)        model = 0;
    else if (l == 0)   model = d;
    else if (ep && et) model = (model == 15) ? 0 : model + 1;
    @(negedge clk);
    check({tag, " count"}, int'(q), model);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: clear with load and enables active
    clr_n = 0; load_n = 0; en_par = 1; en_trk = 1; din = 4'd9;
    @(posedge clk); model = 0; @(negedge clk);
    check("R1 reset clear", int'(q), 0);

    // R8: preset 12, count through the wrap
    step("R8 preset", 1, 0, 0, 0, 12);
    check("R8 seq 12", int'(q), 12);
    begin
      int exp_seq[6] = '{13, 14, 15, 0, 1, 2};
      for (int k = 0; k < 6; k++) begin
        step("R8 R2 count", 1, 1, 1, 1, 0);
        check("R8 seq", int'(q), exp_seq[k]);
      end
    end

    // R3: load with enables low
    step("R3 load", 1, 0, 0, 0, 15);
    check("R3 load value", int'(q), 15);
    // R7: carry high at 15 with en_par low, count holds (R5)
    step("R7 R5 hold par low", 1, 1, 0, 1, 3);
    check("R7 carry par low", int'(carry), 1);
    check("R5 held", int'(q), 15);
    // R6: en_trk low -> carry low, hold
    step("R6 R5 hold trk low", 1, 1, 1, 0, 3);
    check("R6 carry trk low", int'(carry), 0);
    check("R5 held trk", int'(q), 15);
    // R4: clear beats load
    step("R4 clear vs load", 0, 0, 1, 1, 7);
    check("R4 cleared", int'(q), 0);
    // R3 load with only one enable
    step("R3 load ep only", 1, 0, 1, 0, 6);

    // Random control stimulus
    for (int i = 0; i < 400; i++) begin
      int r = $urandom_range(0, 99);
      step("random R2 R3 R5", r >= 4, r < 4 || r >= 18,
           $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0,
           $urandom_range(0, 15));
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule